// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

The block gathers a vector of level-sensitive interrupt sources and drives two request lines toward a processor core: a normal request and a fast request. Each request line has its own enable mask, and a request line is high while any source that is both asserted and enabled for it is active. Software changes each mask only through a pair of registers. One register turns on the bits written as 1, and the other turns them off, so two agents can adjust different bits without a read-modify-write race.

Bit 0 of the level vector can also be driven from software. A write-one action sets a sticky soft bit, and a second write-one action clears it. The soft bit is ORed with external source 0. All registers are reached over a simple word-addressed bus. A write is strobed with `wr_en_i`. Read data is a combinational function of `addr_i`.

Top module: `dual_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, both enable masks and the soft bit are zero and `irq_o` and `fiq_o` are low.
- R2: `irq_o` is registered. After each clock edge it is high exactly when the raw level AND the normal mask was non-zero before that edge.
- R3: `fiq_o` is registered. After each clock edge it is high exactly when the raw level AND the fast mask was non-zero before that edge.
- R4: A write to offset 2 (normal) or offset 10 (fast) ORs `wdata_i` into that mask. A read of the same offset returns the mask.
- R5: A write to offset 3 (normal) or offset 11 (fast) clears the mask bits that are 1 in `wdata_i` and leaves the others unchanged.
- R6: A write to offset 4 with `wdata_i[0]`=1 sets the soft bit. A write to offset 5 with `wdata_i[0]`=1 clears it. With bit 0 at zero, either write has no effect. A read of offset 4 returns only bit 0 of the raw level, with all upper bits zero.
- R7: Reads of offsets 1 and 9 both return the raw level. Bit 0 of the raw level is external source 0 OR the soft bit. Every other bit is its sampled source.
- R8: A read of offset 0 returns the raw level AND the normal mask. A read of offset 8 returns the raw level AND the fast mask.
- R9: Reads of offsets 3, 5, 11 and of the undefined offsets 6, 7 and 12 to 15 return zero.
- R10: Writes to offsets 0, 1, 8 and 9 and to the undefined offsets change neither mask nor the soft bit.
- R11: `src_i` is sampled on every clock edge. The raw level reflects the value present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt sources |
| addr_i | input | ADDR_W | Word offset of the register |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data for `addr_i` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with NUM_SRC=32 and ADDR_W=4. The 4-bit offset covers the whole 16-word window, so random addressing reaches every defined register and every undefined hole, for both reads and writes. The full 32-bit width lets random write data exercise the set and clear behaviour on all mask bits together. It also lets sparse random sources toggle both outputs through partially enabled masks.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_NORM = 0;
  localparam int CH_FAST = 1;

  // Per-channel offsets: channel c sits at base c*8
  localparam int OFS_STAT    = 0;
  localparam int OFS_RAW     = 1;
  localparam int OFS_EN_SET  = 2;
  localparam int OFS_EN_CLR  = 3;
  localparam int OFS_SW_SET  = 4;
  localparam int OFS_SW_CLR  = 5;
  localparam int CH_STRIDE   = 8;

  typedef struct packed {
    logic [NUM_CH-1:0] en_set;
    logic [NUM_CH-1:0] en_clr;
    logic              sw_set;
    logic              sw_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output wr_strobe_t        strb_o
);
  always_comb begin
    strb_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      strb_o.en_set[c] = wr_en_i && (addr_i == ADDR_W'(c * CH_STRIDE + OFS_EN_SET));
      strb_o.en_clr[c] = wr_en_i && (addr_i == ADDR_W'(c * CH_STRIDE + OFS_EN_CLR));
    end
    strb_o.sw_set = wr_en_i && (addr_i == ADDR_W'(OFS_SW_SET));
    strb_o.sw_clr = wr_en_i && (addr_i == ADDR_W'(OFS_SW_CLR));
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_o <= '0;
    else if (set_i) mask_o <= mask_o | wdata_i;
    else if (clr_i) mask_o <= mask_o & ~wdata_i;
  end
endmodule

// File: rtl/irq_src_stage.sv
module irq_src_stage #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         sw_set_i,
  input  logic         sw_clr_i,
  input  logic         wbit0_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] src_q;
  logic         sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      src_q <= src_i;
      if (sw_set_i && wbit0_i)      sw_q <= 1'b1;
      else if (sw_clr_i && wbit0_i) sw_q <= 1'b0;
    end
  end

  assign raw_o = {src_q[W-1:1], src_q[0] | sw_q};
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic         req_o
);
  assign stat_o = raw_i & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= |stat_o;
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  wr_strobe_t                       strb;
  logic [NUM_SRC-1:0]               raw_lvl;
  logic [NUM_CH-1:0][NUM_SRC-1:0]   mask_q;
  logic [NUM_CH-1:0][NUM_SRC-1:0]   stat;
  logic [NUM_CH-1:0]                req;
  logic [NUM_SRC-1:0]               irq_mask;
  logic [NUM_SRC-1:0]               fiq_mask;

  irq_wr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .strb_o (strb)
  );

  irq_src_stage #(.W(NUM_SRC)) i_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .sw_set_i(strb.sw_set),
    .sw_clr_i(strb.sw_clr),
    .wbit0_i (wdata_i[0]),
    .raw_o   (raw_lvl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_mask_reg #(.W(NUM_SRC)) i_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (strb.en_set[c]),
      .clr_i  (strb.en_clr[c]),
      .wdata_i(wdata_i),
      .mask_o (mask_q[c])
    );
    irq_out_stage #(.W(NUM_SRC)) i_out (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_lvl),
      .mask_i(mask_q[c]),
      .stat_o(stat[c]),
      .req_o (req[c])
    );
  end

  assign irq_mask = mask_q[CH_NORM];
  assign fiq_mask = mask_q[CH_FAST];
  assign irq_o    = req[CH_NORM];
  assign fiq_o    = req[CH_FAST];

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(c * CH_STRIDE + OFS_STAT))   rdata_o = stat[c];
      if (addr_i == ADDR_W'(c * CH_STRIDE + OFS_RAW))    rdata_o = raw_lvl;
      if (addr_i == ADDR_W'(c * CH_STRIDE + OFS_EN_SET)) rdata_o = mask_q[c];
    end
    if (addr_i == ADDR_W'(OFS_SW_SET)) rdata_o = {{(NUM_SRC-1){1'b0}}, raw_lvl[0]};
  end
endmodule

// File: rtl/dual_irq_ctrl_sva.sv
module dual_irq_ctrl_sva #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] raw_lvl,
  input logic [NUM_SRC-1:0] irq_mask,
  input logic [NUM_SRC-1:0] fiq_mask
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!irq_o && !fiq_o && irq_mask == '0 && fiq_mask == '0);
    end
  end

  assert_irq_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(raw_lvl & irq_mask)));

  assert_fiq_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fiq_o == $past(|(raw_lvl & fiq_mask)));

  assert_en_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(2)) |=> ((irq_mask & $past(wdata_i)) == $past(wdata_i)));

  assert_en_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(11)) |=> ((fiq_mask & $past(wdata_i)) == '0));

  assert_soft_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(4) && wdata_i[0]) |=> raw_lvl[0]);

  assert_undef_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(5) || addr_i == ADDR_W'(3) || addr_i >= ADDR_W'(12)) |-> rdata_o == '0);

  assert_bad_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == ADDR_W'(0) || addr_i == ADDR_W'(9) || addr_i >= ADDR_W'(12)))
    |=> (irq_mask == $past(irq_mask) && fiq_mask == $past(fiq_mask)));

  assert_sample_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> raw_lvl[NUM_SRC-1:1] == $past(src_i[NUM_SRC-1:1]));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_sva #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .raw_lvl (raw_lvl),
  .irq_mask(irq_mask),
  .fiq_mask(fiq_mask)
);

// File: tb/test_dual_irq_ctrl.sv
`timescale 1ns/1ps
module test_dual_irq_ctrl;
  localparam int N  = 32;
  localparam int AW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_en_i = 1'b0;
  logic [N-1:0]  wdata_i = '0;
  logic [N-1:0]  rdata_o;
  logic          irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dual_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) i_dual_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #5 clk_i = ~clk_i;

  // Reference state built from the requirements
  logic [N-1:0] m_src, m_irq_en, m_fiq_en;
  logic         m_soft, m_irq, m_fiq;

  function automatic logic [N-1:0] m_raw();
    return {m_src[N-1:1], m_src[0] | m_soft};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_src <= '0; m_irq_en <= '0; m_fiq_en <= '0;
      m_soft <= 1'b0; m_irq <= 1'b0; m_fiq <= 1'b0;
    end else begin
      m_irq <= |(m_raw() & m_irq_en);
      m_fiq <= |(m_raw() & m_fiq_en);
      m_src <= src_i;
      if (wr_en_i) begin
        case (addr_i)
          4'd2:  m_irq_en <= m_irq_en | wdata_i;
          4'd3:  m_irq_en <= m_irq_en & ~wdata_i;
          4'd10: m_fiq_en <= m_fiq_en | wdata_i;
          4'd11: m_fiq_en <= m_fiq_en & ~wdata_i;
          4'd4:  if (wdata_i[0]) m_soft <= 1'b1;
          4'd5:  if (wdata_i[0]) m_soft <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] exp_read(input logic [AW-1:0] a);
    case (a)
      4'd0:  return m_raw() & m_irq_en;
      4'd1:  return m_raw();
      4'd2:  return m_irq_en;
      4'd4:  return {{(N-1){1'b0}}, m_raw()[0]};
      4'd8:  return m_raw() & m_fiq_en;
      4'd9:  return m_raw();
      4'd10: return m_fiq_en;
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    if (!rst_ni) return "R1";
    case (a)
      4'd0, 4'd8:  return "R8";
      4'd1, 4'd9:  return "R7/R11";
      4'd2, 4'd10: return "R4/R5/R10";
      4'd4:        return "R6";
      default:     return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: check outputs and read data, then drive and clock
  task automatic cyc(input logic [N-1:0] s, input logic [AW-1:0] a,
                     input logic we, input logic [N-1:0] d);
    @(negedge clk_i);
    check(rst_ni ? "R2" : "R1", N'(irq_o), N'(m_irq));
    check(rst_ni ? "R3" : "R1", N'(fiq_o), N'(m_fiq));
    src_i = s; addr_i = a; wr_en_i = we; wdata_i = d;
    #1;
    check(rd_tag(a), rdata_o, exp_read(a));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    cyc('0, 4'd2, 1'b0, '0);
    cyc('0, 4'd10, 1'b0, '0);
    cyc('0, 4'd4, 1'b1, 32'h1);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc('0, 4'd0, 1'b0, '0);
    // R4/R2: enable all normal, raise source 7
    cyc('0, 4'd2, 1'b1, 32'hFFFF_FFFF);
    cyc(32'h80, 4'd2, 1'b0, '0);
    cyc('0, 4'd0, 1'b0, '0);
    cyc('0, 4'd1, 1'b0, '0);
    // R5: clear some, R3 fast path
    cyc('0, 4'd3, 1'b1, 32'h0000_00F0);
    cyc('0, 4'd10, 1'b1, 32'h0000_0001);
    // R6: soft with bit0 clear has no effect, then set, then clear
    cyc('0, 4'd4, 1'b1, 32'hFFFF_FFFE);
    cyc('0, 4'd4, 1'b1, 32'h1);
    cyc('0, 4'd8, 1'b0, '0);
    cyc('0, 4'd4, 1'b0, '0);
    cyc('0, 4'd5, 1'b1, 32'hFFFF_FFFE);
    cyc('0, 4'd4, 1'b0, '0);
    cyc('0, 4'd5, 1'b1, 32'h1);
    cyc('0, 4'd4, 1'b0, '0);
    // R10: writes to status and holes
    for (int a = 0; a < 16; a++) begin
      if (a inside {0, 1, 6, 7, 8, 9, 12, 13, 14, 15}) begin
        cyc('0, AW'(a), 1'b1, 32'hFFFF_FFFF);
        cyc('0, 4'd2, 1'b0, '0);
        cyc('0, 4'd10, 1'b0, '0);
        cyc('0, 4'd4, 1'b0, '0);
      end
    end
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] s;
      logic [AW-1:0] a;
      s = $urandom & $urandom & $urandom;
      a = AW'($urandom % 16);
      cyc(s, a, ($urandom % 2) == 0, ($urandom % 4 == 0) ? N'($urandom % 2) : $urandom);
    end
    cyc('0, 4'd0, 1'b0, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule